// File: doc/BRIEF.md
# Cascadable Compare and Capture Timer with Interrupts

The block contains two 8-bit up-counters. Each counter has its own compare value. The pair runs either as two independent interval timers or, in cascade mode, as one 16-bit interval timer. A count pulse input (`tick_i`) advances the counters. When a counter reaches its compare value, it returns to zero and raises a request flag. The two compare flags share one compare interrupt line. Software reads the flags to tell which timer fired, and clears a flag by pulsing its clear bit.

A capture unit watches an external pin through a two-flop synchronizer. When the selected edge arrives, it copies the current 16-bit count into a capture register and raises a capture flag. That flag has its own enable bit, its own clear bit and its own interrupt line. Register access is reduced to plain level inputs (data values, start, enables) and one-cycle clear pulses.

Top module: `cascade_cmp_cap_timer`

## Requirements
- R1: After reset every output is zero. A running counter increments by one on each cycle with `tick_i` high, and holds its value on cycles with `tick_i` low.
- R2: A running 8-bit timer whose count equals its compare latch on a tick cycle returns to 0 at that edge and sets its flag. The timer period is therefore compare value plus one ticks.
- R3: A request flag is set by a match and cleared by a one-cycle pulse on its clear bit. When a match and a clear fall on the same cycle, the flag ends up set. Otherwise the flag holds its value.
- R4: `cmp_irq_o` is high exactly when `flag_o[0]` and `irq_en_i[0]` are both 1, or when `flag_o[1]` and `irq_en_i[1]` are both 1 and `mode16_i` is 0.
- R5: With `mode16_i`=1, `cnt_o` is one 16-bit counter run by `start_i[0]`. It is compared with {`cmp1_data_i`, `cmp0_data_i`}. A match returns the count to 0 and sets only `flag_o[0]`, and `flag_o[1]` never sets in this mode.
- R6: The compare latch copies the data input only while its timer is stopped or at the edge where the count restarts. A data change during a running period has no effect until the next restart.
- R7: A timer whose start bit is 0 reads count 0 one cycle later and stays at 0.
- R8: `cap_sel_i` picks the capture edge: 00 none, 01 rising, 10 falling, 11 both. A selected edge on `cap_in_i` loads `cap_val_o` with the count, three clock edges after the pin changes. The loaded value is the count present in the cycle before the loading edge.
- R9: A capture event sets `cap_flag_o`. A pulse on `cap_clr_i` clears it, except on a cycle with a capture event, where set wins. `cap_irq_o` equals `cap_flag_o` AND `cap_ien_i`.
- R10: With `cap_en_i`=0, pin edges change neither `cap_val_o` nor `cap_flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count pulse enable |
| mode16_i | input | 1 | 1: cascade into one 16-bit timer |
| start_i | input | 2 | Run bit per timer (bit 1 unused in cascade mode) |
| cmp0_data_i | input | 8 | Compare value, timer 0 / low byte |
| cmp1_data_i | input | 8 | Compare value, timer 1 / high byte |
| irq_en_i | input | 2 | Compare interrupt enable per timer |
| flag_clr_i | input | 2 | Write-one clear pulse per compare flag |
| cap_en_i | input | 1 | Capture mode enable |
| cap_sel_i | input | 2 | Capture edge select |
| cap_in_i | input | 1 | Asynchronous capture pin |
| cap_ien_i | input | 1 | Capture interrupt enable |
| cap_clr_i | input | 1 | Write-one clear pulse for capture flag |
| cnt_o | output | 16 | {timer 1 count, timer 0 count} |
| flag_o | output | 2 | Compare request flags |
| cmp_irq_o | output | 1 | Shared compare interrupt |
| cap_val_o | output | 16 | Captured count |
| cap_flag_o | output | 1 | Capture request flag |
| cap_irq_o | output | 1 | Capture interrupt |

## Verification
Count, compare flag and latch effects appear one clock edge after the cycle holding the tick, clear or start input. The interrupt lines follow the flags and enables in the same cycle. A pin edge reaches the capture value and capture flag on the third edge after the pin changes. The bench keeps a reference model, updated at every rising edge from the inputs driven at the preceding falling edge, and compares all outputs at the next falling edge. Every result is therefore checked in the exact cycle it is due. Directed runs also count edges explicitly for the 8-bit and 16-bit periods.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned TMR_W  = 8;
  localparam int unsigned N_TMR  = 2;
  localparam int unsigned SYNC_N = 2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cct_slice.sv
module cct_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         inc_i,
  input  logic         restart_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] lat_o
);
  logic [W-1:0] cnt_q, lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else if (!run_i || restart_i) begin
      cnt_q <= '0;
      lat_q <= data_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign lat_o = lat_q;

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !inc_i && !restart_i |=> $stable(cnt_q)); // R1
  AST_LATCH_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !restart_i |=> $stable(lat_q)); // R6
endmodule

// File: rtl/cct_req_flag.sv
module cct_req_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q); // R3
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_q); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !set_i |=> $stable(flag_q)); // R3
endmodule

// File: rtl/cct_capture.sv
module cct_capture
  import cct_pkg::*;
#(
  parameter int unsigned CW   = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    sel_i,
  input  logic          pin_i,
  input  logic [CW-1:0] cnt_i,
  output logic          evt_o,
  output logic [CW-1:0] val_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic [CW-1:0]   val_q;
  logic            pin_s, rise, fall;
  edge_sel_e       sel;

  generate
    if (SYNC == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC-2:0], pin_i};
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC-1];
  assign sel   = edge_sel_e'(sel_i);
  assign rise  = pin_s & ~prev_q;
  assign fall  = ~pin_s & prev_q;

  always_comb begin
    unique case (sel)
      EDGE_RISE: evt_o = en_i & rise;
      EDGE_FALL: evt_o = en_i & fall;
      EDGE_BOTH: evt_o = en_i & (rise | fall);
      default:   evt_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      val_q  <= '0;
    end else begin
      prev_q <= pin_s;
      if (evt_o) val_q <= cnt_i;
    end
  end

  assign val_o = val_q;

  AST_CAP_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> val_q == $past(cnt_i)); // R8
  AST_CAP_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_o |=> $stable(val_q)); // R8
  AST_CAP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !evt_o); // R10
endmodule

// File: rtl/cascade_cmp_cap_timer.sv
module cascade_cmp_cap_timer
  import cct_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 mode16_i,
  input  logic [N_TMR-1:0]     start_i,
  input  logic [TMR_W-1:0]     cmp0_data_i,
  input  logic [TMR_W-1:0]     cmp1_data_i,
  input  logic [N_TMR-1:0]     irq_en_i,
  input  logic [N_TMR-1:0]     flag_clr_i,
  input  logic                 cap_en_i,
  input  logic [1:0]           cap_sel_i,
  input  logic                 cap_in_i,
  input  logic                 cap_ien_i,
  input  logic                 cap_clr_i,
  output logic [2*TMR_W-1:0]   cnt_o,
  output logic [N_TMR-1:0]     flag_o,
  output logic                 cmp_irq_o,
  output logic [2*TMR_W-1:0]   cap_val_o,
  output logic                 cap_flag_o,
  output logic                 cap_irq_o
);
  localparam int unsigned CW = N_TMR * TMR_W;

  logic [N_TMR-1:0][TMR_W-1:0] cnt, lat, data;
  logic [N_TMR-1:0]            run, inc, restart, eq8, set, irq;
  logic                        eq16, cap_evt;

  assign data[0] = cmp0_data_i;
  assign data[1] = cmp1_data_i;
  assign eq16    = &eq8;

  // timer 1 becomes the high byte in cascade mode
  always_comb begin
    run[0]     = start_i[0];
    inc[0]     = tick_i;
    restart[0] = start_i[0] & tick_i & (mode16_i ? eq16 : eq8[0]);
    if (mode16_i) begin
      run[1]     = start_i[0];
      inc[1]     = tick_i & (cnt[0] == '1);
      restart[1] = restart[0];
    end else begin
      run[1]     = start_i[1];
      inc[1]     = tick_i;
      restart[1] = start_i[1] & tick_i & eq8[1];
    end
    set[0] = restart[0];
    set[1] = restart[1] & ~mode16_i;
  end

  generate
    for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
      assign eq8[k] = (cnt[k] == lat[k]);

      cct_slice #(.W(TMR_W)) u_slice (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run[k]),
        .inc_i     (inc[k]),
        .restart_i (restart[k]),
        .data_i    (data[k]),
        .cnt_o     (cnt[k]),
        .lat_o     (lat[k])
      );

      cct_req_flag u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set[k]),
        .clr_i  (flag_clr_i[k]),
        .en_i   (irq_en_i[k]),
        .flag_o (flag_o[k]),
        .irq_o  (irq[k])
      );
    end
  endgenerate

  assign cnt_o     = {cnt[1], cnt[0]};
  assign cmp_irq_o = irq[0] | (irq[1] & ~mode16_i);

  cct_capture #(.CW(CW), .SYNC(SYNC_N)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cap_en_i),
    .sel_i  (cap_sel_i),
    .pin_i  (cap_in_i),
    .cnt_i  (cnt_o),
    .evt_o  (cap_evt),
    .val_o  (cap_val_o)
  );

  cct_req_flag u_cap_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cap_evt),
    .clr_i  (cap_clr_i),
    .en_i   (cap_ien_i),
    .flag_o (cap_flag_o),
    .irq_o  (cap_irq_o)
  );

  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart[0] |=> cnt[0] == '0); // R2
  AST_CASCADE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode16_i && !(flag_o[0] && irq_en_i[0]) |-> !cmp_irq_o); // R5
  AST_CAP_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_ien_i |-> !cap_irq_o); // R9
endmodule

// File: tb/cascade_cmp_cap_timer_test.sv
`timescale 1ns/1ps
module cascade_cmp_cap_timer_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_i = 0, mode16_i = 0, cap_en_i = 0, cap_in_i = 0, cap_ien_i = 0, cap_clr_i = 0;
  logic [1:0] start_i = 0, irq_en_i = 0, flag_clr_i = 0, cap_sel_i = 0;
  logic [7:0] cmp0_data_i = 0, cmp1_data_i = 0;
  logic [15:0] cnt_o, cap_val_o;
  logic [1:0] flag_o;
  logic cmp_irq_o, cap_flag_o, cap_irq_o;

  int total = 0, bad = 0;
  string cur_req = "R1", cap_req = "R8";

  // reference state
  logic [7:0]  m_c0, m_c1, m_l0, m_l1;
  logic        m_f0, m_f1, m_cf, m_s1, m_s2, m_sp;
  logic [15:0] m_cv;

  always #2 clk_i = ~clk_i;

  cascade_cmp_cap_timer uut (.*);

  function automatic logic cap_hit(logic en, logic [1:0] sel, logic now, logic prev);
    return en & ((sel[0] & now & ~prev) | (sel[1] & ~now & prev));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    logic s0, s1, ev;
    logic [15:0] c16, l16;
    if (!rst_ni) begin
      {m_c0, m_c1, m_l0, m_l1} = '0;
      {m_f0, m_f1, m_cf, m_s1, m_s2, m_sp} = '0;
      m_cv = '0;
    end else begin
      s0 = 0; s1 = 0;
      ev = cap_hit(cap_en_i, cap_sel_i, m_s2, m_sp);
      if (ev) m_cv = {m_c1, m_c0};
      if (mode16_i) begin
        c16 = {m_c1, m_c0}; l16 = {m_l1, m_l0};
        if (!start_i[0]) begin c16 = 0; l16 = {cmp1_data_i, cmp0_data_i}; end
        else if (tick_i) begin
          if (c16 == l16) begin c16 = 0; l16 = {cmp1_data_i, cmp0_data_i}; s0 = 1; end
          else c16 = c16 + 1;
        end
        {m_c1, m_c0} = c16; {m_l1, m_l0} = l16;
      end else begin
        if (!start_i[0]) begin m_c0 = 0; m_l0 = cmp0_data_i; end
        else if (tick_i) begin
          if (m_c0 == m_l0) begin m_c0 = 0; m_l0 = cmp0_data_i; s0 = 1; end
          else m_c0 = m_c0 + 1;
        end
        if (!start_i[1]) begin m_c1 = 0; m_l1 = cmp1_data_i; end
        else if (tick_i) begin
          if (m_c1 == m_l1) begin m_c1 = 0; m_l1 = cmp1_data_i; s1 = 1; end
          else m_c1 = m_c1 + 1;
        end
      end
      m_f0 = s0 ? 1'b1 : (flag_clr_i[0] ? 1'b0 : m_f0);
      m_f1 = s1 ? 1'b1 : (flag_clr_i[1] ? 1'b0 : m_f1);
      m_cf = ev ? 1'b1 : (cap_clr_i ? 1'b0 : m_cf);
      m_sp = m_s2; m_s2 = m_s1; m_s1 = cap_in_i;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(cur_req, "cnt", cnt_o, {m_c1, m_c0});
    check(cur_req, "flag", flag_o, {m_f1, m_f0});
    check("R4", "cmp_irq", cmp_irq_o,
          (m_f0 & irq_en_i[0]) | (m_f1 & irq_en_i[1] & ~mode16_i));
    check(cap_req, "cap_val", cap_val_o, m_cv);
    check("R9", "cap_flag", cap_flag_o, m_cf);
    check("R9", "cap_irq", cap_irq_o, m_cf & cap_ien_i);
  endtask

  task automatic step();
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic rnd(int tick_pct, int clr_pct, int pin_pct);
    tick_i     = ($urandom % 100) < tick_pct;
    flag_clr_i = {(($urandom % 100) < clr_pct), (($urandom % 100) < clr_pct)};
    cap_clr_i  = ($urandom % 100) < clr_pct;
    if (($urandom % 100) < pin_pct) cap_in_i = ~cap_in_i;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1", "reset cnt", cnt_o, 0);
    check("R1", "reset flag", flag_o, 0);
    check("R1", "reset irq", {cmp_irq_o, cap_irq_o, cap_flag_o}, 0);
    check("R8", "reset cap_val", cap_val_o, 0);
    rst_ni = 1'b1;
    step();

    // R2 directed 8-bit period: compare value 4 -> flag after 5 ticks
    cur_req = "R2";
    cmp0_data_i = 8'd4; cmp1_data_i = 8'd9; irq_en_i = 2'b11;
    step();
    start_i = 2'b11; tick_i = 1;
    for (int i = 0; i < 4; i++) step();
    check("R2", "cnt0 before match", cnt_o[7:0], 8'd4);
    check("R2", "flag0 before match", flag_o[0], 1'b0);
    step();
    check("R2", "cnt0 after match", cnt_o[7:0], 8'd0);
    check("R2", "flag0 after match", flag_o[0], 1'b1);
    for (int i = 0; i < 60; i++) begin step(); rnd(80, 10, 0); end

    // R3 set wins over clear: compare value 0 matches every tick
    cur_req = "R3";
    cmp0_data_i = 0; start_i = 0; step(); start_i = 2'b11; tick_i = 1;
    for (int i = 0; i < 40; i++) begin
      step(); flag_clr_i = $urandom % 4; tick_i = ($urandom % 3) != 0;
    end
    flag_clr_i = 2'b01; tick_i = 1; step(); step();
    check("R3", "set beats clear", flag_o[0], 1'b1);
    flag_clr_i = 0;

    // R6 data changes mid-period
    cur_req = "R6";
    cmp0_data_i = 8'd20; cmp1_data_i = 8'd30; start_i = 0; step(); start_i = 2'b11;
    for (int i = 0; i < 200; i++) begin
      step(); rnd(90, 5, 0);
      if (($urandom % 8) == 0) cmp0_data_i = $urandom % 32;
      if (($urandom % 8) == 0) cmp1_data_i = $urandom % 32;
    end

    // R7 start/stop
    cur_req = "R7";
    for (int i = 0; i < 300; i++) begin
      step(); rnd(70, 10, 0);
      if (($urandom % 10) == 0) start_i = $urandom % 4;
    end
    start_i = 2'b00; step(); step();
    check("R7", "stopped count", cnt_o, 16'd0);

    // R5 cascade: compare 0x0102 -> flag0 after 0x103 ticks
    cur_req = "R5";
    mode16_i = 1; cmp0_data_i = 8'h02; cmp1_data_i = 8'h01;
    flag_clr_i = 2'b11; tick_i = 0; step(); flag_clr_i = 0; step();
    start_i = 2'b01; tick_i = 1;
    for (int i = 0; i < 16'h102; i++) step();
    check("R5", "cnt16 before match", cnt_o, 16'h0102);
    check("R5", "flag0 before match", flag_o[0], 1'b0);
    step();
    check("R5", "cnt16 after match", cnt_o, 16'h0000);
    check("R5", "flag0 after match", flag_o[0], 1'b1);
    check("R5", "flag1 idle", flag_o[1], 1'b0);
    for (int i = 0; i < 1500; i++) begin
      step(); rnd(95, 3, 0); irq_en_i = $urandom % 4;
    end

    // R8/R9 capture, each edge code
    cur_req = "R1"; mode16_i = 0; start_i = 2'b11;
    cmp0_data_i = 8'd200; cmp1_data_i = 8'd150;
    cap_en_i = 1; cap_ien_i = 1;
    for (int s = 0; s < 4; s++) begin
      cap_sel_i = s[1:0];
      for (int i = 0; i < 300; i++) begin
        step(); rnd(60, 8, 25); cap_ien_i = ($urandom % 4) != 0;
      end
    end
    // directed rising-edge latency: three edges
    cap_sel_i = 2'b01; cap_in_i = 0; cap_clr_i = 0;
    repeat (4) step();
    flag_clr_i = 0; cap_clr_i = 1; step(); cap_clr_i = 0;
    cap_in_i = 1; tick_i = 1;
    step(); step();
    check("R8", "flag before 3rd edge", cap_flag_o, 1'b0);
    step();
    check("R8", "flag at 3rd edge", cap_flag_o, 1'b1);
    check("R9", "cap irq", cap_irq_o, cap_ien_i);

    // R10 capture disabled
    cap_req = "R10"; cap_en_i = 0; cap_sel_i = 2'b11;
    for (int i = 0; i < 300; i++) begin step(); rnd(60, 0, 40); end
    cap_req = "R8";

    // mixed random
    cur_req = "R1";
    for (int i = 0; i < 12000; i++) begin
      step(); rnd(70, 6, 15);
      if (($urandom % 50) == 0) start_i = $urandom % 4;
      if (($urandom % 400) == 0) mode16_i = ~mode16_i;
      if (($urandom % 30) == 0) cmp0_data_i = $urandom % 64;
      if (($urandom % 30) == 0) cmp1_data_i = mode16_i ? $urandom % 2 : $urandom % 64;
      if (($urandom % 60) == 0) cap_sel_i = $urandom % 4;
      if (($urandom % 60) == 0) cap_en_i = $urandom % 2;
      irq_en_i = ($urandom % 8 == 0) ? $urandom % 4 : irq_en_i;
      cap_ien_i = ($urandom % 8 == 0) ? $urandom % 2 : cap_ien_i;
    end
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule